// File: doc/BRIEF.md
# Serial Converter Command and Capture Engine

This block is the host side of a four-wire link to a 12-bit sampling converter. It drives chip select, the serial clock and the command line, and it reads the converter's data line. A request carries three command fields: a single-ended/differential select, a polarity select, and an order select. The engine accepts a request and lowers chip select. It sends a start bit and the three command bits, lets one null period pass, and then clocks in the result most significant bit first.

When the order select is zero, the converter follows the least significant bit with a reversed copy of bits 1 through 11. The engine rebuilds that copy into a word, with bit 0 shared with the first pass, and compares it with the forward word. The result word and a mismatch flag are offered on a valid/ready output. The engine takes no new request until that result has been consumed. The serial clock comes from a programmable divider of the system clock.

The controller has four states. In `ST_IDLE` it waits for a request. `ST_XFER` runs the serial frame. In `ST_GAP` chip select is high and the clock is parked. `ST_RESULT` holds the result until it is taken. The transitions are as follows:
- IDLE→XFER when a request is accepted.
- XFER→GAP on the falling clock edge that ends the last period of the frame.
- GAP→RESULT after the minimum chip-select-high time.
- RESULT→IDLE when the consumer accepts the result.

Top module: `adc_cmd_engine`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, res_valid is 0 and req_ready is 1.
- R2: On the first four sclk rising edges of a frame, mosi carries, in this order: 1 (the start bit), req_single, req_odd and req_msbf.
- R3: A frame has exactly 17 sclk rising edges when req_msbf is 1, and exactly 28 when it is 0.
- R4: The 5th rising edge is a null period. Result bits D11 down to D0 are sampled from miso on rising edges 6 to 17, and res_data returns that word.
- R5: When req_msbf is 0, miso on rising edges 18 to 28 is taken as D1 up to D11. res_mismatch is 1 exactly when {those bits, D0} differs from res_data. It is always 0 when req_msbf is 1.
- R6: sclk is 0 whenever cs_n is 1. Between frames, cs_n stays high for at least 2 sclk periods (4·HALF_DIV clock cycles).
- R7: From acceptance until the result is consumed, req_ready is 0. While res_valid is 1 and res_ready is 0, res_valid, res_data and res_mismatch hold their values.
- R8: Inside a frame, every sclk high and low phase lasts HALF_DIV clock cycles.
- R9: When res_ready and req_valid are both 1 in the same cycle, the result is consumed in that cycle. req_ready is 1 in the next cycle, and the pending request is accepted at the end of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine can accept a request |
| req_single | input | 1 | 1 = single-ended input, 0 = differential |
| req_odd | input | 1 | Polarity / channel select |
| req_msbf | input | 1 | 1 = forward order only, 0 = forward plus reversed copy |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | RES_W | Conversion result |
| res_mismatch | output | 1 | Reversed copy disagreed with forward word |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock to converter |
| mosi | output | 1 | Command line to converter |
| miso | input | 1 | Data line from converter |

## Verification
Two events can land in the same cycle: consumption of a finished result and the arrival of the next request. The bench raises res_ready and req_valid together at one edge. It then judges three things. req_ready must rise only in the following cycle. The request must be accepted one cycle after that. The new frame must still respect the minimum chip-select-high gap. A converter model in the bench decodes the command bits and can corrupt one reversed bit, so the mismatch flag is judged from both sides.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_XFER   = 2'd1,
        ST_GAP    = 2'd2,
        ST_RESULT = 2'd3
    } eng_state_t;

    // start bit + three command bits + one null period
    localparam int HDR_LEN = 5;
endpackage

// File: rtl/sclk_pacer.sv
module sclk_pacer #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (!run)       cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/result_capture.sv
module result_capture #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             fwd_en,
    input  logic             rev_en,
    input  logic             bit_in,
    output logic [RES_W-1:0] fwd_word,
    output logic [RES_W-2:0] rev_word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fwd_word <= '0;
            rev_word <= '0;
        end else if (clear) begin
            fwd_word <= '0;
            rev_word <= '0;
        end else begin
            if (fwd_en) fwd_word <= {fwd_word[RES_W-2:0], bit_in};
            // reversed copy arrives low bit first: shift in at the top
            if (rev_en) rev_word <= {bit_in, rev_word[RES_W-2:1]};
        end
    end
endmodule

// File: rtl/adc_cmd_engine.sv
module adc_cmd_engine
    import adc_host_pkg::*;
#(
    parameter int RES_W       = 12,
    parameter int HALF_DIV    = 2,
    parameter int GAP_PERIODS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_single,
    input  logic             req_odd,
    input  logic             req_msbf,
    output logic             res_valid,
    input  logic             res_ready,
    output logic [RES_W-1:0] res_data,
    output logic             res_mismatch,
    output logic             cs_n,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso
);
    localparam int FWD_LEN   = HDR_LEN + RES_W;
    localparam int DUAL_LEN  = FWD_LEN + RES_W - 1;
    localparam int PW        = $clog2(DUAL_LEN);
    localparam int GAP_TICKS = 2 * GAP_PERIODS;
    localparam int GW        = $clog2(GAP_TICKS + 1);

    eng_state_t state, state_nx;

    logic          tick;
    logic          phase;
    logic [PW-1:0] pidx;
    logic [GW-1:0] gap_cnt;
    logic          cmd_single, cmd_odd, cmd_msbf;
    logic          last_period, gap_done;
    logic          accept, rise_now;
    logic          fwd_en, rev_en;
    logic [RES_W-1:0] fwd_word;
    logic [RES_W-2:0] rev_word;

    function automatic logic cmd_bit(input int idx, input logic s, input logic o, input logic m);
        case (idx)
            0:       cmd_bit = 1'b1;
            1:       cmd_bit = s;
            2:       cmd_bit = o;
            3:       cmd_bit = m;
            default: cmd_bit = 1'b0;
        endcase
    endfunction

    sclk_pacer #(.HALF_DIV(HALF_DIV)) u_pacer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  ((state == ST_XFER) || (state == ST_GAP)),
        .tick (tick)
    );

    assign accept      = (state == ST_IDLE) && req_valid;
    assign rise_now    = (state == ST_XFER) && tick && !phase;
    assign last_period = int'(pidx) == (cmd_msbf ? FWD_LEN - 1 : DUAL_LEN - 1);
    assign gap_done    = int'(gap_cnt) == GAP_TICKS - 1;
    assign fwd_en      = rise_now && int'(pidx) >= HDR_LEN && int'(pidx) < FWD_LEN;
    assign rev_en      = rise_now && int'(pidx) >= FWD_LEN;

    result_capture #(.RES_W(RES_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .fwd_en  (fwd_en),
        .rev_en  (rev_en),
        .bit_in  (miso),
        .fwd_word(fwd_word),
        .rev_word(rev_word)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (req_valid)                   state_nx = ST_XFER;
            ST_XFER:   if (tick && phase && last_period) state_nx = ST_GAP;
            ST_GAP:    if (tick && gap_done)            state_nx = ST_RESULT;
            ST_RESULT: if (res_ready)                   state_nx = ST_IDLE;
            default:                                    state_nx = ST_IDLE;
        endcase
    end

    // outputs and frame counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n       <= 1'b1;
            sclk       <= 1'b0;
            mosi       <= 1'b0;
            phase      <= 1'b0;
            pidx       <= '0;
            gap_cnt    <= '0;
            res_valid  <= 1'b0;
            cmd_single <= 1'b0;
            cmd_odd    <= 1'b0;
            cmd_msbf   <= 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    cmd_single <= req_single;
                    cmd_odd    <= req_odd;
                    cmd_msbf   <= req_msbf;
                    cs_n       <= 1'b0;
                    sclk       <= 1'b0;
                    mosi       <= 1'b1;
                    phase      <= 1'b0;
                    pidx       <= '0;
                end
                ST_XFER: if (tick) begin
                    if (!phase) begin
                        sclk  <= 1'b1;
                        phase <= 1'b1;
                    end else begin
                        sclk  <= 1'b0;
                        phase <= 1'b0;
                        if (last_period) begin
                            cs_n    <= 1'b1;
                            mosi    <= 1'b0;
                            gap_cnt <= '0;
                        end else begin
                            pidx <= pidx + 1'b1;
                            mosi <= cmd_bit(int'(pidx) + 1, cmd_single, cmd_odd, cmd_msbf);
                        end
                    end
                end
                ST_GAP: if (tick) begin
                    gap_cnt <= gap_cnt + 1'b1;
                    if (gap_done) res_valid <= 1'b1;
                end
                ST_RESULT: if (res_ready) res_valid <= 1'b0;
                default: ;
            endcase
        end
    end

    assign req_ready    = (state == ST_IDLE);
    assign res_data     = fwd_word;
    assign res_mismatch = !cmd_msbf && ({rev_word, fwd_word[0]} != fwd_word);

    AST_SCLK_NEEDS_CS:  assert property (@(posedge clk) disable iff (!rst_n) sclk |-> !cs_n);                 // R6
    AST_RESULT_PARKED:  assert property (@(posedge clk) disable iff (!rst_n) $rose(res_valid) |-> cs_n && !sclk); // R6
    AST_BUSY_NO_READY:  assert property (@(posedge clk) disable iff (!rst_n) (!cs_n || res_valid) |-> !req_ready); // R7
    AST_RESULT_HOLD:    assert property (@(posedge clk) disable iff (!rst_n)
                            res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_mismatch)); // R7
    AST_HANDSHAKE_FREE: assert property (@(posedge clk) disable iff (!rst_n) res_valid && res_ready |=> req_ready); // R9
endmodule

// File: tb/sim_adc_cmd_engine.sv
`timescale 1ns/1ps
module sim_adc_cmd_engine;
    localparam int RES_W = 12;
    localparam int HALF  = 2;
    localparam real TCLK = 4.0;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_single = 0, req_odd = 0, req_msbf = 1, res_ready = 0;
    logic req_ready, res_valid, res_mismatch, cs_n, sclk, mosi;
    logic miso = 0;
    logic [RES_W-1:0] res_data;

    int n_tests = 0, n_fail = 0;

    // converter model state
    logic [11:0] m_word = '0;
    int          m_flip = 0;   // 0 = none, k = corrupt reversed bit Dk
    int          rcount = 0;
    logic [3:0]  cfg_seen = '0;
    int          hi_run = 0, last_gap = 0;
    int          pace_bad = 0;
    realtime     last_edge = 0.0;

    adc_cmd_engine #(.RES_W(RES_W), .HALF_DIV(HALF), .GAP_PERIODS(2)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_single(req_single), .req_odd(req_odd), .req_msbf(req_msbf),
        .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
        .res_mismatch(res_mismatch), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    always #(TCLK/2) clk = ~clk;

    function automatic logic model_bit(input int n);
        int k;
        if (n >= 6 && n <= 17) return m_word[17 - n];
        if (n >= 18 && n <= 28 && !cfg_seen[0]) begin
            k = n - 17;
            return m_word[k] ^ (m_flip == k);
        end
        return 1'b0;
    endfunction

    always @(negedge cs_n) begin
        rcount    = 0;
        last_edge = 0.0;
        last_gap  = hi_run;
        miso      = 1'b0;
    end

    always @(posedge sclk) if (!cs_n) begin
        rcount = rcount + 1;
        if (rcount <= 4) cfg_seen[4 - rcount] = mosi;
    end

    always @(negedge sclk) if (!cs_n) miso = model_bit(rcount + 1);

    always @(sclk) if (!cs_n) begin
        if (last_edge != 0.0 && ($realtime - last_edge) != HALF * TCLK) pace_bad = pace_bad + 1;
        last_edge = $realtime;
    end

    always @(posedge clk) hi_run <= cs_n ? hi_run + 1 : 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_req(input logic s, input logic o, input logic m);
        @(negedge clk);
        req_single = s; req_odd = o; req_msbf = m; req_valid = 1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic await_and_check(input logic s, input logic o, input logic m,
                                   input bit check_gap);
        logic exp_mm;
        pace_bad = 0;
        while (!res_valid) @(negedge clk);
        check(cfg_seen == {1'b1, s, o, m}, "R2 command bits", cfg_seen, {1'b1, s, o, m});
        check(rcount == (m ? 17 : 28), "R3 rising edge count", rcount, m ? 17 : 28);
        check(res_data == m_word, "R4 result word", res_data, m_word);
        exp_mm = !m && (m_flip != 0);
        check(res_mismatch == exp_mm, "R5 mismatch flag", res_mismatch, exp_mm);
        check(pace_bad == 0, "R8 half period length", pace_bad, 0);
        if (check_gap) check(last_gap >= 4 * HALF, "R6 chip select gap", last_gap, 4 * HALF);
    endtask

    task automatic consume;
        res_ready = 1;
        @(negedge clk);
        res_ready = 0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(cs_n == 1 && sclk == 0 && res_valid == 0 && req_ready == 1,
              "R1 reset state", {cs_n, sclk, res_valid, req_ready}, 4'b1001);
    endtask

    task automatic t_frame(input logic [11:0] w, input logic s, input logic o,
                           input logic m, input int flip, input bit gap);
        m_word = w; m_flip = flip;
        send_req(s, o, m);
        await_and_check(s, o, m, gap);
        consume();
    endtask

    task automatic t_backpressure;
        logic [11:0] held;
        m_word = 12'hA5C; m_flip = 3;
        send_req(1'b0, 1'b1, 1'b0);
        await_and_check(1'b0, 1'b1, 1'b0, 1'b1);
        held = res_data;
        req_valid = 1;
        for (int i = 0; i < 6; i++) @(negedge clk);
        check(res_valid == 1 && res_data == held && res_mismatch == 1,
              "R7 result held", res_data, held);
        check(req_ready == 0 && cs_n == 1, "R7 no accept while busy", req_ready, 0);
        req_valid = 0;
        consume();
    endtask

    task automatic t_same_cycle;
        m_word = 12'h3C1; m_flip = 0;
        send_req(1'b1, 1'b1, 1'b1);
        await_and_check(1'b1, 1'b1, 1'b1, 1'b1);
        m_word = 12'hE07; m_flip = 0;
        req_single = 0; req_odd = 0; req_msbf = 0;
        req_valid = 1; res_ready = 1;
        @(negedge clk);
        res_ready = 0;
        check(req_ready == 1 && res_valid == 0, "R9 ready after handshake", req_ready, 1);
        @(negedge clk);
        check(req_ready == 0 && cs_n == 0, "R9 request accepted next cycle", cs_n, 0);
        req_valid = 0;
        await_and_check(1'b0, 1'b0, 1'b0, 1'b1);
        consume();
    endtask

    initial begin
        #(TCLK * 200000);
        n_fail++; n_tests++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_frame(12'h8F1, 1'b1, 1'b0, 1'b1, 0, 1'b0);
        t_frame(12'h5A6, 1'b0, 1'b1, 1'b0, 0, 1'b1);
        t_frame(12'hFFF, 1'b1, 1'b1, 1'b0, 0, 1'b1);
        t_frame(12'h001, 1'b0, 1'b0, 1'b0, 11, 1'b1);
        t_frame(12'h800, 1'b1, 1'b0, 1'b0, 1, 1'b1);
        t_frame(12'h7E3, 1'b0, 1'b1, 1'b1, 5, 1'b1);
        t_backpressure();
        t_same_cycle();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule